// File: doc/BRIEF.md
# Address-Linked Replay Queue with Transient Line Buffer

This block parks coherence requests whose target line is busy in a transient state. Each parked request takes one slot from a 16-entry pool. Requests for the same line are chained by next pointers. A small match table records, for each line that has waiters, the first and the last entry of its chain. A request is therefore appended in one cycle, and the chain is walked later without searching the pool.

Alongside the queue sits a transient buffer indexed by transaction identifier. It holds the line address of the request that moved a line into a transient state, plus a one-line data buffer. The data buffer starts empty. A supply or writeback message fills it and marks it full. When the resolving message arrives, the caller releases the entry by identifier. The block then presents the entry's address, data and full flag for servicing, and marks that line's chain for replay.

The replay engine drains one marked chain at a time, one request per cycle, in arrival order. Other lines stay parked, and new requests keep being accepted while a chain drains.

Top module: `addr_replay_queue`

## Requirements
- R1: `enq_ready_o` is low exactly when no pool entry is free, or when the offered address has no chain and every match-table slot is in use. An enqueue offered while `enq_ready_o` is low changes nothing and is never replayed.
- R2: Requests for one address are replayed in the order in which they were accepted.
- R3: A chain is not replayed until a transient-buffer entry holding the same address is released.
- R4: Replay presents at most one request per cycle. A marked chain of N requests appears on N consecutive cycles, and each replayed entry is returned to the pool.
- R5: Releasing one address replays only that address's chain. Chains for other addresses stay parked and intact, and requests to a line that already has a chain are still accepted when the match table is full.
- R6: Allocating a transient-buffer entry marks its line buffer empty, so a release without an earlier fill gives `svc_full_o` = 0.
- R7: A fill to an allocated entry stores the data and marks it full. The following release gives `svc_full_o` = 1 and that data on `svc_data_o`.
- R8: A release of an allocated identifier raises `svc_valid_o` on the next cycle, with the entry's address, and removes the entry. A release of an identifier with no entry gives no `svc_valid_o`.
- R9: After reset, `enq_ready_o` is high, and `replay_valid_o` and `svc_valid_o` are low.
- R10: After a full pool has been replayed, all 16 entries can be used again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enq_valid_i | input | 1 | Offer a request to park |
| enq_addr_i | input | ADDR_W (16) | Line address of the offered request |
| enq_tid_i | input | TID_W (3) | Transaction identifier of the offered request |
| enq_ready_o | output | 1 | Request accepted this cycle if offered |
| tb_alloc_i | input | 1 | Allocate a transient-buffer entry |
| tb_alloc_tid_i | input | TID_W (3) | Identifier of the entry to allocate |
| tb_alloc_addr_i | input | ADDR_W (16) | Line address held by the new entry |
| tb_fill_i | input | 1 | Supply or writeback data for an entry |
| tb_fill_tid_i | input | TID_W (3) | Identifier of the entry to fill |
| tb_fill_data_i | input | LINE_W (32) | Line data |
| tb_rel_i | input | 1 | Resolving message: release an entry |
| tb_rel_tid_i | input | TID_W (3) | Identifier of the entry to release |
| svc_valid_o | output | 1 | Released entry presented for service |
| svc_addr_o | output | ADDR_W (16) | Address of the released entry |
| svc_full_o | output | 1 | Line buffer of the released entry was full |
| svc_data_o | output | LINE_W (32) | Line buffer contents |
| replay_valid_o | output | 1 | A parked request is replayed this cycle |
| replay_addr_o | output | ADDR_W (16) | Address of the replayed request |
| replay_tid_o | output | TID_W (3) | Identifier of the replayed request |

## Verification
The bound checker keeps a running count of parked requests, taken from accepted enqueues and replay cycles. On every cycle it checks that replay never runs with nothing parked, that acceptance is offered when the pool is empty, and that it is refused when the pool is full. It also checks that service output follows a release on the cycle before. Replay order within a chain, the way chains wait for their own release, the isolation between addresses, the empty/full state of the line buffer and the reuse of the pool can only be seen through the bench's scenarios. Those scenarios compare the replayed sequence and the service fields against values worked out from the requirements.

// File: rtl/rq_pkg.sv
package rq_pkg;
  parameter int unsigned RQ_DEPTH_DEF  = 16;
  parameter int unsigned AMT_SLOTS_DEF = 4;
  parameter int unsigned ADDR_W_DEF    = 16;
  parameter int unsigned TID_W_DEF     = 3;
  parameter int unsigned LINE_W_DEF    = 32;

  typedef enum logic [1:0] {
    OP_ENQ   = 2'd0,
    OP_ALLOC = 2'd1,
    OP_FILL  = 2'd2,
    OP_REL   = 2'd3
  } rq_op_e;
endpackage

// File: rtl/rq_free_list.sv
module rq_free_list #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_i,
  input  logic             free_i,
  input  logic [IDX_W-1:0] free_idx_i,
  output logic             avail_o,
  output logic [IDX_W-1:0] alloc_idx_o
);
  logic [DEPTH-1:0] busy_q;

  // lowest free entry wins
  always_comb begin
    avail_o     = 1'b0;
    alloc_idx_o = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!busy_q[i]) begin
        avail_o     = 1'b1;
        alloc_idx_o = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= '0;
    end else begin
      if (free_i) busy_q[free_idx_i] <= 1'b0;
      if (alloc_i) busy_q[alloc_idx_o] <= 1'b1;
    end
  end
endmodule

// File: rtl/rq_tb_store.sv
module rq_tb_store #(
  parameter int unsigned TID_W  = 3,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned LINE_W = 32,
  localparam int unsigned N_ENT = 1 << TID_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  logic [TID_W-1:0]  alloc_tid_i,
  input  logic [ADDR_W-1:0] alloc_addr_i,
  input  logic              fill_i,
  input  logic [TID_W-1:0]  fill_tid_i,
  input  logic [LINE_W-1:0] fill_data_i,
  input  logic              rel_i,
  input  logic [TID_W-1:0]  rel_tid_i,
  output logic              rel_hit_o,
  output logic [ADDR_W-1:0] rel_addr_o,
  output logic              svc_valid_o,
  output logic [ADDR_W-1:0] svc_addr_o,
  output logic              svc_full_o,
  output logic [LINE_W-1:0] svc_data_o
);
  logic [N_ENT-1:0]  ent_v_q;
  logic [N_ENT-1:0]  ent_full_q;
  logic [ADDR_W-1:0] ent_addr_q [N_ENT];
  logic [LINE_W-1:0] ent_data_q [N_ENT];

  assign rel_hit_o  = rel_i && ent_v_q[rel_tid_i];
  assign rel_addr_o = ent_addr_q[rel_tid_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ent_v_q     <= '0;
      ent_full_q  <= '0;
      svc_valid_o <= 1'b0;
      svc_addr_o  <= '0;
      svc_full_o  <= 1'b0;
      svc_data_o  <= '0;
      for (int i = 0; i < N_ENT; i++) begin
        ent_addr_q[i] <= '0;
        ent_data_q[i] <= '0;
      end
    end else begin
      svc_valid_o <= rel_hit_o;
      svc_addr_o  <= ent_addr_q[rel_tid_i];
      svc_full_o  <= ent_full_q[rel_tid_i];
      svc_data_o  <= ent_data_q[rel_tid_i];
      if (fill_i && ent_v_q[fill_tid_i]) begin
        ent_data_q[fill_tid_i] <= fill_data_i;
        ent_full_q[fill_tid_i] <= 1'b1;
      end
      if (rel_hit_o) ent_v_q[rel_tid_i] <= 1'b0;
      if (alloc_i) begin
        ent_v_q[alloc_tid_i]    <= 1'b1;
        ent_addr_q[alloc_tid_i] <= alloc_addr_i;
        ent_full_q[alloc_tid_i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/addr_replay_queue.sv
module addr_replay_queue
  import rq_pkg::*;
#(
  parameter int unsigned RQ_DEPTH  = RQ_DEPTH_DEF,
  parameter int unsigned AMT_SLOTS = AMT_SLOTS_DEF,
  parameter int unsigned ADDR_W    = ADDR_W_DEF,
  parameter int unsigned TID_W     = TID_W_DEF,
  parameter int unsigned LINE_W    = LINE_W_DEF,
  localparam int unsigned IDX_W    = $clog2(RQ_DEPTH),
  localparam int unsigned SLOT_W   = (AMT_SLOTS > 1) ? $clog2(AMT_SLOTS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enq_valid_i,
  input  logic [ADDR_W-1:0] enq_addr_i,
  input  logic [TID_W-1:0]  enq_tid_i,
  output logic              enq_ready_o,
  input  logic              tb_alloc_i,
  input  logic [TID_W-1:0]  tb_alloc_tid_i,
  input  logic [ADDR_W-1:0] tb_alloc_addr_i,
  input  logic              tb_fill_i,
  input  logic [TID_W-1:0]  tb_fill_tid_i,
  input  logic [LINE_W-1:0] tb_fill_data_i,
  input  logic              tb_rel_i,
  input  logic [TID_W-1:0]  tb_rel_tid_i,
  output logic              svc_valid_o,
  output logic [ADDR_W-1:0] svc_addr_o,
  output logic              svc_full_o,
  output logic [LINE_W-1:0] svc_data_o,
  output logic              replay_valid_o,
  output logic [ADDR_W-1:0] replay_addr_o,
  output logic [TID_W-1:0]  replay_tid_o
);
  // entry pool (link store)
  logic [TID_W-1:0] ent_tid_q  [RQ_DEPTH];
  logic [IDX_W-1:0] ent_next_q [RQ_DEPTH];

  // address match table
  logic [AMT_SLOTS-1:0] slot_v_q, slot_go_q;
  logic [ADDR_W-1:0]    slot_addr_q [AMT_SLOTS];
  logic [IDX_W-1:0]     slot_head_q [AMT_SLOTS];
  logic [IDX_W-1:0]     slot_tail_q [AMT_SLOTS];

  logic              cur_active_q;
  logic [SLOT_W-1:0] cur_slot_q;

  logic              fl_avail, enq_fire;
  logic [IDX_W-1:0]  fl_idx, pop_idx;
  logic              hit, fs_avail, go_any, pop_last, enq_join;
  logic [SLOT_W-1:0] hit_idx, fs_idx, go_idx;
  logic              rel_hit;
  logic [ADDR_W-1:0] rel_addr;

  rq_free_list #(.DEPTH(RQ_DEPTH)) i_free_list (
    .clk_i, .rst_ni,
    .alloc_i    (enq_fire),
    .free_i     (cur_active_q),
    .free_idx_i (pop_idx),
    .avail_o    (fl_avail),
    .alloc_idx_o(fl_idx)
  );

  rq_tb_store #(.TID_W(TID_W), .ADDR_W(ADDR_W), .LINE_W(LINE_W)) i_tb_store (
    .clk_i, .rst_ni,
    .alloc_i     (tb_alloc_i),
    .alloc_tid_i (tb_alloc_tid_i),
    .alloc_addr_i(tb_alloc_addr_i),
    .fill_i      (tb_fill_i),
    .fill_tid_i  (tb_fill_tid_i),
    .fill_data_i (tb_fill_data_i),
    .rel_i       (tb_rel_i),
    .rel_tid_i   (tb_rel_tid_i),
    .rel_hit_o   (rel_hit),
    .rel_addr_o  (rel_addr),
    .svc_valid_o, .svc_addr_o, .svc_full_o, .svc_data_o
  );

  always_comb begin
    hit = 1'b0; hit_idx = '0;
    fs_avail = 1'b0; fs_idx = '0;
    go_any = 1'b0; go_idx = '0;
    for (int s = AMT_SLOTS - 1; s >= 0; s--) begin
      if (slot_v_q[s] && slot_addr_q[s] == enq_addr_i) begin
        hit = 1'b1; hit_idx = SLOT_W'(s);
      end
      if (!slot_v_q[s]) begin
        fs_avail = 1'b1; fs_idx = SLOT_W'(s);
      end
      if (slot_v_q[s] && slot_go_q[s]) begin
        go_any = 1'b1; go_idx = SLOT_W'(s);
      end
    end
  end

  assign enq_ready_o = fl_avail && (hit || fs_avail);
  assign enq_fire    = enq_valid_i && enq_ready_o;
  assign pop_idx     = slot_head_q[cur_slot_q];
  assign pop_last    = pop_idx == slot_tail_q[cur_slot_q];
  // append to a chain whose last entry leaves this cycle: new entry becomes head
  assign enq_join    = enq_fire && hit && cur_active_q && hit_idx == cur_slot_q && pop_last;

  assign replay_valid_o = cur_active_q;
  assign replay_addr_o  = slot_addr_q[cur_slot_q];
  assign replay_tid_o   = ent_tid_q[pop_idx];

  always_ff @(posedge clk_i) begin
    if (enq_fire) begin
      ent_tid_q[fl_idx] <= enq_tid_i;
      if (hit) ent_next_q[slot_tail_q[hit_idx]] <= fl_idx;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_v_q     <= '0;
      slot_go_q    <= '0;
      cur_active_q <= 1'b0;
      cur_slot_q   <= '0;
      for (int s = 0; s < AMT_SLOTS; s++) begin
        slot_addr_q[s] <= '0;
        slot_head_q[s] <= '0;
        slot_tail_q[s] <= '0;
      end
    end else begin
      for (int s = 0; s < AMT_SLOTS; s++)
        if (rel_hit && slot_v_q[s] && slot_addr_q[s] == rel_addr) slot_go_q[s] <= 1'b1;

      if (cur_active_q) begin
        if (pop_last && !enq_join) begin
          slot_v_q[cur_slot_q]  <= 1'b0;
          slot_go_q[cur_slot_q] <= 1'b0;
          cur_active_q          <= 1'b0;
        end else if (!pop_last) begin
          slot_head_q[cur_slot_q] <= ent_next_q[pop_idx];
        end
      end else if (go_any) begin
        cur_active_q      <= 1'b1;
        cur_slot_q        <= go_idx;
        slot_go_q[go_idx] <= 1'b0;
      end

      if (enq_fire) begin
        if (hit) begin
          slot_tail_q[hit_idx] <= fl_idx;
          if (enq_join) slot_head_q[hit_idx] <= fl_idx;
        end else begin
          slot_v_q[fs_idx]    <= 1'b1;
          slot_go_q[fs_idx]   <= 1'b0;
          slot_addr_q[fs_idx] <= enq_addr_i;
          slot_head_q[fs_idx] <= fl_idx;
          slot_tail_q[fs_idx] <= fl_idx;
        end
      end
    end
  end
endmodule

// File: rtl/addr_replay_queue_chk.sv
module addr_replay_queue_chk #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH) + 1
) (
  input logic clk_i,
  input logic rst_ni,
  input logic enq_valid_i,
  input logic enq_ready_o,
  input logic tb_rel_i,
  input logic svc_valid_o,
  input logic replay_valid_o
);
  logic [CNT_W-1:0] occ_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) occ_q <= '0;
    else occ_q <= occ_q + CNT_W'(enq_valid_i && enq_ready_o) - CNT_W'(replay_valid_o);
  end

  AST_REPLAY_NEEDS_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    replay_valid_o |-> occ_q != '0); // R4
  AST_READY_WHEN_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_q == '0 |-> enq_ready_o); // R1
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_q == CNT_W'(DEPTH) |-> !enq_ready_o); // R1
  AST_SVC_AFTER_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc_valid_o |-> $past(tb_rel_i)); // R8
endmodule

bind addr_replay_queue addr_replay_queue_chk #(.DEPTH(RQ_DEPTH)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .enq_valid_i(enq_valid_i), .enq_ready_o(enq_ready_o),
  .tb_rel_i(tb_rel_i), .svc_valid_o(svc_valid_o), .replay_valid_o(replay_valid_o)
);

// File: tb/test_addr_replay_queue.sv
module test_addr_replay_queue;
  import rq_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int N_ROWS = 10;
  // row: op[29:28] addr[27:12] tid[11:9] data[8:1] exp_full[0]
  localparam logic [29:0] VEC [N_ROWS] = '{
    {OP_ALLOC, 16'h0010, 3'd1, 8'h00, 1'b0},
    {OP_ALLOC, 16'h0020, 3'd2, 8'h00, 1'b0},
    {OP_ENQ,   16'h0010, 3'd3, 8'h00, 1'b0},
    {OP_ENQ,   16'h0020, 3'd4, 8'h00, 1'b0},
    {OP_ENQ,   16'h0010, 3'd5, 8'h00, 1'b0},
    {OP_ENQ,   16'h0020, 3'd6, 8'h00, 1'b0},
    {OP_ENQ,   16'h0010, 3'd7, 8'h00, 1'b0},
    {OP_FILL,  16'h0000, 3'd1, 8'h5A, 1'b0},
    {OP_REL,   16'h0020, 3'd2, 8'h00, 1'b0},
    {OP_REL,   16'h0010, 3'd1, 8'h5A, 1'b1}
  };
  localparam logic [15:0] EXP_ADDR [5] = '{16'h0020, 16'h0020, 16'h0010, 16'h0010, 16'h0010};
  localparam logic [2:0]  EXP_TID  [5] = '{3'd4, 3'd6, 3'd3, 3'd5, 3'd7};

  logic clk = 1'b0, rst_n = 1'b0;
  logic enq_valid, tb_alloc, tb_fill, tb_rel;
  logic [15:0] enq_addr, tb_alloc_addr;
  logic [2:0] enq_tid, tb_alloc_tid, tb_fill_tid, tb_rel_tid;
  logic [31:0] tb_fill_data;
  logic enq_ready, svc_valid, svc_full, replay_valid;
  logic [15:0] svc_addr, replay_addr;
  logic [31:0] svc_data;
  logic [2:0] replay_tid;

  int n_chk = 0, n_bad = 0, cyc = 0, log_n = 0;
  bit done = 0;
  logic [15:0] log_addr [64];
  logic [2:0]  log_tid  [64];
  int          log_cyc  [64];

  addr_replay_queue i_addr_replay_queue (
    .clk_i(clk), .rst_ni(rst_n),
    .enq_valid_i(enq_valid), .enq_addr_i(enq_addr), .enq_tid_i(enq_tid), .enq_ready_o(enq_ready),
    .tb_alloc_i(tb_alloc), .tb_alloc_tid_i(tb_alloc_tid), .tb_alloc_addr_i(tb_alloc_addr),
    .tb_fill_i(tb_fill), .tb_fill_tid_i(tb_fill_tid), .tb_fill_data_i(tb_fill_data),
    .tb_rel_i(tb_rel), .tb_rel_tid_i(tb_rel_tid),
    .svc_valid_o(svc_valid), .svc_addr_o(svc_addr), .svc_full_o(svc_full), .svc_data_o(svc_data),
    .replay_valid_o(replay_valid), .replay_addr_o(replay_addr), .replay_tid_o(replay_tid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (rst_n && replay_valid && log_n < 64) begin
      log_addr[log_n] = replay_addr;
      log_tid[log_n]  = replay_tid;
      log_cyc[log_n]  = cyc;
      log_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    enq_valid = 0; tb_alloc = 0; tb_fill = 0; tb_rel = 0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
    end
  end

  initial begin
    int base;
    logic [29:0] prev;
    idle();
    enq_addr = 0; enq_tid = 0; tb_alloc_addr = 0; tb_alloc_tid = 0;
    tb_fill_tid = 0; tb_fill_data = 0; tb_rel_tid = 0;
    prev = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(enq_ready === 1'b1, "R9 ready", enq_ready, 1);
    chk(replay_valid === 1'b0, "R9 replay", replay_valid, 0);
    chk(svc_valid === 1'b0, "R9 svc", svc_valid, 0);

    // table walk: two interleaved chains, fill, releases
    for (int r = 0; r < N_ROWS; r++) begin
      @(negedge clk);
      if (prev[29:28] == OP_REL) begin
        chk(svc_valid === 1'b1, "R8 svc valid", svc_valid, 1);
        chk(svc_addr === prev[27:12], "R8 svc addr", svc_addr, prev[27:12]);
        chk(svc_full === prev[0], prev[0] ? "R7 full" : "R6 empty", svc_full, prev[0]);
        if (prev[0]) chk(svc_data === {24'h0, prev[8:1]}, "R7 data", svc_data, prev[8:1]);
      end
      idle();
      case (VEC[r][29:28])
        OP_ENQ:   begin enq_valid = 1; enq_addr = VEC[r][27:12]; enq_tid = VEC[r][11:9]; end
        OP_ALLOC: begin tb_alloc = 1; tb_alloc_addr = VEC[r][27:12]; tb_alloc_tid = VEC[r][11:9]; end
        OP_FILL:  begin tb_fill = 1; tb_fill_tid = VEC[r][11:9]; tb_fill_data = {24'h0, VEC[r][8:1]}; end
        default:  begin tb_rel = 1; tb_rel_tid = VEC[r][11:9]; end
      endcase
      #1;
      if (VEC[r][29:28] == OP_ENQ) chk(enq_ready === 1'b1, "R1 accept", enq_ready, 1);
      prev = VEC[r];
    end
    @(negedge clk);
    chk(svc_valid === 1'b1 && svc_full === 1'b1 && svc_data === 32'h5A, "R7 svc", svc_data, 32'h5A);
    idle();
    repeat (20) @(negedge clk);
    chk(log_n == 5, "R5 count", log_n, 5);
    for (int i = 0; i < 5; i++) begin
      chk(log_addr[i] === EXP_ADDR[i], "R5 addr", log_addr[i], EXP_ADDR[i]);
      chk(log_tid[i] === EXP_TID[i], "R2 order", log_tid[i], EXP_TID[i]);
    end
    chk(log_cyc[1] == log_cyc[0] + 1, "R4 consecutive", log_cyc[1], log_cyc[0] + 1);
    chk(log_cyc[4] == log_cyc[2] + 2, "R4 consecutive", log_cyc[4], log_cyc[2] + 2);

    // match table full: four addresses, a fifth is refused, a hit still accepted
    base = log_n;
    for (int a = 0; a < 4; a++) begin
      @(negedge clk);
      idle(); enq_valid = 1; enq_addr = 16'h0100 + 16'(a); enq_tid = 3'(a);
    end
    @(negedge clk);
    idle(); enq_valid = 1; enq_addr = 16'h0104; enq_tid = 3'd4;
    #1;
    chk(enq_ready === 1'b0, "R1 table full", enq_ready, 0);
    @(negedge clk);
    idle(); enq_addr = 16'h0101;
    #1;
    chk(enq_ready === 1'b1, "R5 hit accepted", enq_ready, 1);
    chk(log_n == base, "R3 no replay before release", log_n, base);
    for (int a = 0; a < 4; a++) begin
      @(negedge clk);
      idle(); tb_alloc = 1; tb_alloc_tid = 3'(a); tb_alloc_addr = 16'h0100 + 16'(a);
    end
    for (int a = 0; a < 4; a++) begin
      @(negedge clk);
      idle(); tb_rel = 1; tb_rel_tid = 3'(a);
    end
    @(negedge clk);
    idle();
    repeat (20) @(negedge clk);
    chk(log_n == base + 4, "R1 refused not replayed", log_n, base + 4);
    for (int i = base; i < log_n; i++)
      chk(log_addr[i] != 16'h0104, "R1 refused addr", log_addr[i], 0);

    // full pool on one address
    base = log_n;
    @(negedge clk);
    idle(); tb_alloc = 1; tb_alloc_tid = 3'd5; tb_alloc_addr = 16'h0200;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      idle(); enq_valid = 1; enq_addr = 16'h0200; enq_tid = 3'(i % 8);
      #1;
      chk(enq_ready === 1'b1, "R10 fill pool", enq_ready, 1);
    end
    @(negedge clk);
    idle(); enq_valid = 1; enq_addr = 16'h0200; enq_tid = 3'd7;
    #1;
    chk(enq_ready === 1'b0, "R1 pool full", enq_ready, 0);
    @(negedge clk);
    idle(); enq_addr = 16'h0300;
    #1;
    chk(enq_ready === 1'b0, "R1 pool full new addr", enq_ready, 0);
    repeat (4) @(negedge clk);
    chk(log_n == base, "R3 waits for release", log_n, base);
    tb_rel = 1; tb_rel_tid = 3'd5;
    @(negedge clk);
    idle();
    chk(svc_valid === 1'b1 && svc_addr === 16'h0200, "R8 svc", svc_addr, 16'h0200);
    chk(svc_full === 1'b0, "R6 empty", svc_full, 0);
    repeat (30) @(negedge clk);
    chk(log_n == base + 16, "R4 count", log_n, base + 16);
    for (int i = 0; i < 16; i++) begin
      chk(log_tid[base+i] === 3'(i % 8), "R2 order", log_tid[base+i], i % 8);
      chk(log_cyc[base+i] == log_cyc[base] + i, "R4 one per cycle", log_cyc[base+i], log_cyc[base] + i);
    end
    enq_addr = 16'h0300;
    #1;
    chk(enq_ready === 1'b1, "R10 pool reusable", enq_ready, 1);

    // second release of same identifier
    @(negedge clk);
    idle(); tb_rel = 1; tb_rel_tid = 3'd5;
    @(negedge clk);
    idle();
    chk(svc_valid === 1'b0, "R8 stale release", svc_valid, 0);

    done = 1;
    summary();
  end
endmodule